// File: doc/BRIEF.md
# Asymmetric Integrating Input Filter

This block cleans up one noisy digital input by integrating it. The raw input first passes through a two-stage synchronizer. A saturating accumulator then climbs by a programmable rise step on every clock in which the synchronized sample is high, and drops by a separate programmable decay step on every clock in which it is low. The filtered level only changes state when the accumulator crosses one of two programmable bounds. It goes high at or above the upper bound and low at or below the lower bound. The gap between the bounds gives hysteresis, so short bursts of noise shift the accumulator without moving the output.

Both steps and both bounds are plain inputs, sampled on every clock. They can be retuned while the filter runs, and the next comparison uses the new values. Choosing unequal steps lets a user trade reaction speed against noise rejection separately for each edge. At a 100 MHz clock a one-microsecond delay budget is 100 cycles. For a level change, the total delay is the number of steps needed to cross the bound plus three register stages, so steps and bounds are chosen to fit inside that budget.

The level decision is a two-state machine. State `LV_LOW` moves to `LV_HIGH` on transition ARM, when the accumulator is at or above the upper bound and the configuration is valid. State `LV_HIGH` moves to `LV_LOW` on transition RELEASE, when the accumulator is at or below the lower bound and the configuration is valid. In every other case each state holds. A configuration is invalid when the lower bound is not strictly below the upper bound. In that case the state machine freezes and the fault output is raised.

Top module: `integ_filter_top`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator clears to zero, the synchronizer clears, `level_out` goes low, and both strobes go low.
- R2: The raw input reaches the accumulator only through a two-register synchronizer, so a change on `raw_in` first alters the accumulator at the third clock edge after it.
- R3: With `level_out` low, the accumulator at zero and `raw_in` held high, `level_out` rises at clock edge ceil(`thr_full`/`step_rise`)+3, counted from the change on `raw_in`.
- R4: With `level_out` high, the accumulator at value A and `raw_in` held low, `level_out` falls at clock edge ceil((A−`thr_empty`)/`step_decay`)+3.
- R5: The accumulator saturates at 2^ACC_W−1 and never wraps past it, so after a long high input it sits at 2^ACC_W−1.
- R6: The accumulator saturates at zero and never wraps below it.
- R7: While the accumulator lies strictly between the two bounds, `level_out` keeps its value. A high burst that is too short to reach `thr_full` leaves the output low.
- R8: `rise_pulse` is high for exactly the one cycle in which `level_out` has just gone from 0 to 1, and `fall_pulse` likewise for 1 to 0. The two strobes are never high together.
- R9: When `thr_empty` ≥ `thr_full`, `cfg_fault` is high in the same cycle and `level_out` holds its value, whatever the accumulator holds.
- R10: The bounds take effect on the first clock after they change. If the accumulator already sits at or above a newly valid `thr_full`, `level_out` rises at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Unsynchronized noisy input |
| step_rise | input | ACC_W | Amount added per clock while the sample is high |
| step_decay | input | ACC_W | Amount subtracted per clock while the sample is low |
| thr_full | input | ACC_W | Upper bound; at or above it the level goes high |
| thr_empty | input | ACC_W | Lower bound; at or below it the level goes low |
| level_out | output | 1 | Filtered level |
| rise_pulse | output | 1 | One-cycle strobe on a low-to-high level change |
| fall_pulse | output | 1 | One-cycle strobe on a high-to-low level change |
| cfg_fault | output | 1 | High while the bounds are inconsistent |

## Verification
The hardest case to reach is an accumulator that has already passed the upper bound while the state machine cannot move. The bench reaches it by making the configuration invalid first. It then holds the input high long enough to drive the accumulator into saturation, and checks that the level stays frozen. Finally it repairs the lower bound and expects a rise on the very next edge. The ceiling saturation is shown through timing alone: the fall delay after a long high input matches only an accumulator pinned at its maximum. The floor saturation is shown the same way, because a wrapped accumulator would rise almost at once.

// File: rtl/ifilt_pkg.sv
package ifilt_pkg;
    typedef enum logic [0:0] {
        LV_LOW  = 1'b0,
        LV_HIGH = 1'b1
    } lvl_state_t;
endpackage

// File: rtl/ifilt_sync.sv
module ifilt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ifilt_accum.sv
module ifilt_accum #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample,
    input  logic [W-1:0] step_rise,
    input  logic [W-1:0] step_decay,
    output logic [W-1:0] acc
);
    localparam logic [W-1:0] ACC_MAX = {W{1'b1}};

    logic [W:0]   sum_up;
    logic [W-1:0] up_val;
    logic [W-1:0] down_val;
    logic [W-1:0] acc_q;

    always_comb begin
        sum_up   = {1'b0, acc_q} + {1'b0, step_rise};
        up_val   = sum_up[W] ? ACC_MAX : sum_up[W-1:0];
        down_val = (acc_q < step_decay) ? '0 : (acc_q - step_decay);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (sample) begin
            acc_q <= up_val;
        end else begin
            acc_q <= down_val;
        end
    end

    assign acc = acc_q;
endmodule

// File: rtl/ifilt_level_fsm.sv
module ifilt_level_fsm
    import ifilt_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] thr_full,
    input  logic [W-1:0] thr_empty,
    output logic         level,
    output logic         rise,
    output logic         fall,
    output logic         fault
);
    lvl_state_t state_q;
    lvl_state_t state_d;
    logic       arm_hit;
    logic       release_hit;

    assign fault       = (thr_empty >= thr_full);
    assign arm_hit     = !fault && (acc >= thr_full);
    assign release_hit = !fault && (acc <= thr_empty);

    // next-state selection: ARM and RELEASE, otherwise hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_LOW:  if (arm_hit)     state_d = LV_HIGH;
            LV_HIGH: if (release_hit) state_d = LV_LOW;
            default: state_d = LV_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LV_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // registered strobes, aligned with the state change
    always_ff @(posedge clk) begin
        if (rst) begin
            rise <= 1'b0;
            fall <= 1'b0;
        end else begin
            rise <= (state_q == LV_LOW)  && (state_d == LV_HIGH);
            fall <= (state_q == LV_HIGH) && (state_d == LV_LOW);
        end
    end

    assign level = (state_q == LV_HIGH);
endmodule

// File: rtl/integ_filter_top.sv
module integ_filter_top #(
    parameter int ACC_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_in,
    input  logic [ACC_W-1:0] step_rise,
    input  logic [ACC_W-1:0] step_decay,
    input  logic [ACC_W-1:0] thr_full,
    input  logic [ACC_W-1:0] thr_empty,
    output logic             level_out,
    output logic             rise_pulse,
    output logic             fall_pulse,
    output logic             cfg_fault
);
    logic             sync_q;
    logic [ACC_W-1:0] acc_q;

    ifilt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_q)
    );

    ifilt_accum #(.W(ACC_W)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .sample     (sync_q),
        .step_rise  (step_rise),
        .step_decay (step_decay),
        .acc        (acc_q)
    );

    ifilt_level_fsm #(.W(ACC_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc_q),
        .thr_full  (thr_full),
        .thr_empty (thr_empty),
        .level     (level_out),
        .rise      (rise_pulse),
        .fall      (fall_pulse),
        .fault     (cfg_fault)
    );
endmodule

// File: rtl/integ_filter_chk.sv
module integ_filter_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         s_in,
    input logic [W-1:0] acc,
    input logic [W-1:0] thr_full,
    input logic [W-1:0] thr_empty,
    input logic         level_out,
    input logic         rise_pulse,
    input logic         fall_pulse,
    input logic         cfg_fault
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!level_out && !rise_pulse && !fall_pulse && acc == '0));

    p_rise_needs_full_r3: assert property (@(posedge clk) disable iff (rst)
        (!level_out && !cfg_fault && acc >= thr_full) |=> level_out);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        s_in |=> (acc >= $past(acc)));

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        !s_in |=> (acc <= $past(acc)));

    p_hold_between_r7: assert property (@(posedge clk) disable iff (rst)
        (level_out && acc > thr_empty) |=> level_out);

    p_rise_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |-> (level_out && !$past(level_out)));

    p_fall_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        fall_pulse |-> (!level_out && $past(level_out)));

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(rise_pulse && fall_pulse));

    p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_fault |=> $stable(level_out));
endmodule

bind integ_filter_top integ_filter_chk #(.W(ACC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .s_in       (sync_q),
    .acc        (acc_q),
    .thr_full   (thr_full),
    .thr_empty  (thr_empty),
    .level_out  (level_out),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse),
    .cfg_fault  (cfg_fault)
);

// File: tb/integ_filter_top_tb_top.sv
`timescale 1ns/1ps
module integ_filter_top_tb_top;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         raw_in = 1'b0;
    logic [W-1:0] step_rise = 10'd16;
    logic [W-1:0] step_decay = 10'd5;
    logic [W-1:0] thr_full = 10'd600;
    logic [W-1:0] thr_empty = 10'd200;
    logic         level_out, rise_pulse, fall_pulse, cfg_fault;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    integ_filter_top dut_i (
        .clk(clk), .rst(rst), .raw_in(raw_in),
        .step_rise(step_rise), .step_decay(step_decay),
        .thr_full(thr_full), .thr_empty(thr_empty),
        .level_out(level_out), .rise_pulse(rise_pulse),
        .fall_pulse(fall_pulse), .cfg_fault(cfg_fault)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // count edges until level_out equals want; report strobe at that edge
    task automatic wait_level(input logic want, input int limit,
                              output int cnt, output logic strobe);
        cnt = 0;
        strobe = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            #1;
            cnt++;
            if (level_out == want) begin
                strobe = want ? rise_pulse : fall_pulse;
                break;
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 level after reset", int'(level_out), 0);
        check("R1 rise strobe after reset", int'(rise_pulse), 0);
        check("R1 fall strobe after reset", int'(fall_pulse), 0);
        check("R9 fault low with valid bounds", int'(cfg_fault), 0);
    endtask

    task automatic t_rise_latency();
        int c; logic s;
        raw_in = 1'b1;
        wait_level(1'b1, 200, c, s);
        check("R3 rise latency (R2 sync)", c, 41);   // ceil(600/16)+3
        check("R8 rise strobe with level", int'(s), 1);
        tick(1);
        check("R8 rise strobe one cycle", int'(rise_pulse), 0);
    endtask

    task automatic t_fall_after_saturation();
        int c; logic s;
        tick(200);                                    // accumulator pinned at 1023
        raw_in = 1'b0;
        wait_level(1'b0, 400, c, s);
        check("R4 R5 fall latency from saturated max", c, 168); // ceil(823/5)+3
        check("R8 fall strobe with level", int'(s), 1);
        tick(1);
        check("R8 fall strobe one cycle", int'(fall_pulse), 0);
    endtask

    task automatic t_glitch_reject();
        int seen = 0;
        tick(100);
        raw_in = 1'b1;
        tick(10);                                     // at most 160 < 600
        raw_in = 1'b0;
        for (int i = 0; i < 60; i++) begin
            tick(1);
            if (level_out) seen++;
        end
        check("R7 short burst leaves level low", seen, 0);
    endtask

    task automatic t_floor();
        int c; logic s;
        tick(300);                                    // long low: floor at zero
        raw_in = 1'b1;
        wait_level(1'b1, 200, c, s);
        check("R6 rise latency from floor", c, 41);
        raw_in = 1'b0;
        tick(400);
    endtask

    task automatic t_fault_and_runtime();
        int seen = 0;
        do_reset();
        thr_empty = 10'd600;                          // equal bounds: invalid
        tick(1);
        check("R9 fault flag on equal bounds", int'(cfg_fault), 1);
        raw_in = 1'b1;
        for (int i = 0; i < 120; i++) begin
            tick(1);
            if (level_out || rise_pulse) seen++;
        end
        check("R9 level frozen under fault", seen, 0);
        thr_empty = 10'd200;                          // repair at run time
        tick(1);
        check("R10 rise on first edge after repair", int'(level_out), 1);
        raw_in = 1'b0;
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_rise_latency();
                t_fall_after_saturation();
                t_glitch_reject();
                t_floor();
                t_fault_and_runtime();
            end
            begin
                while (cycles < 100000) begin
                    @(posedge clk);
                    cycles++;
                end
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule